// File: doc/BRIEF.md
# Watchdog Event Steering Register

This block is the system control and status register that sits beside a watchdog counter. When the counter expires, the block sends the event to one of two active-low outputs: a reset line or an interrupt line. The selected line is held low for a fixed number of oscillator-clock cycles. A status bit, brought into the system-clock domain, reports the interrupt line back to software. This lets software confirm that the interrupt has gone away before it enters a low-power state.

The register also holds a sticky override lock. While the lock is set, the watchdog control logic may disable the watchdog. Once software clears the lock, disable requests are ignored until the next device reset. Every register write passes through a write-protect gate.

If software turns off interrupt steering while an interrupt pulse is still active, the interrupt is released. At the same moment, a fresh full-length reset pulse starts.

Top module: `wd_event_steer`

## Requirements
- R1: After reset, `rd_data_o` reads 0x0005, `wd_rst_no` is 1, `wd_int_no` is 1 and `wd_disable_o` follows `dis_req_i`.
- R2: Bits 15..3 of `rd_data_o` always read 0, even after a write of all ones.
- R3: A write with `wr_en_i` high changes the register only while `prot_en_i` is high. Otherwise bits 1 and 0 keep their values.
- R4: Bit 1 is the steering bit, read/write, with reset value 0. While it is 0, an expiry on `expire_i` drives `wd_rst_no` low and `wd_int_no` stays 1.
- R5: While bit 1 is 1, an expiry drives `wd_int_no` low and `wd_rst_no` stays 1.
- R6: The selected output is low for exactly PULSE_LEN (default 512) oscillator cycles. The output falls after the oscillator edge that samples `expire_i` high.
- R7: An expiry that arrives while a pulse is active is ignored. The pulse is neither restarted nor lengthened.
- R8: If bit 1 is cleared while `wd_int_no` is low, then on the same oscillator edge `wd_int_no` rises and `wd_rst_no` falls. This happens three oscillator edges after the write edge, two of them in the synchronizer. That reset pulse lasts a full PULSE_LEN cycles.
- R9: Bit 2 is read-only and equals `wd_int_no` delayed by two system-clock edges (0 = interrupt active).
- R10: Bit 0 is the override lock, with reset value 1. A protected write with bit 0 = 1 clears it. A write with bit 0 = 0 has no effect. Once 0, it stays 0 until `rst_ni` is asserted.
- R11: `wd_disable_o` equals `dis_req_i` while bit 0 is 1, and is 0 while bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock (register side) |
| osc_clk_i | input | 1 | Oscillator clock (pulse side) |
| rst_ni | input | 1 | Asynchronous active-low device reset |
| wr_en_i | input | 1 | Register write strobe |
| prot_en_i | input | 1 | Write-protect release; writes count only while high |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Register read value |
| expire_i | input | 1 | Watchdog counter expiry, oscillator domain |
| dis_req_i | input | 1 | Disable request from the watchdog control register |
| wd_disable_o | output | 1 | Qualified disable to the watchdog counter |
| wd_rst_no | output | 1 | Active-low watchdog reset pulse |
| wd_int_no | output | 1 | Active-low watchdog interrupt pulse |

## Verification
Two events can land together. A software write that clears the steering bit can reach the pulse logic in the same oscillator cycle as a fresh counter expiry, while an interrupt pulse is still running. The bench writes the bit partway through an interrupt pulse and raises `expire_i` so that it lands on the cycle the synchronized bit arrives. It expects the interrupt to rise and the reset to fall on that exact edge. It then expects a reset pulse of exactly 512 cycles, which shows that the expiry neither added a second pulse nor shortened the restarted one.

// File: rtl/wdes_pkg.sv
package wdes_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned BIT_LOCK = 0;
  localparam int unsigned BIT_STEER = 1;
  localparam int unsigned BIT_STS  = 2;
  localparam logic [REG_W-1:0] WR_MASK = REG_W'((1 << BIT_LOCK) | (1 << BIT_STEER));
endpackage

// File: rtl/wdes_sync.sv
module wdes_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdes_regs.sv
module wdes_regs
  import wdes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             prot_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             sts_i,
  output logic             steer_o,
  output logic             lock_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic steer_q, lock_q;
  logic wr_ok;

  assign wr_ok = wr_en_i & prot_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q <= 1'b0;
      lock_q  <= 1'b1;
    end else if (wr_ok) begin
      steer_q <= wr_data_i[BIT_STEER];
      if (wr_data_i[BIT_LOCK]) lock_q <= 1'b0; // clear-only
    end
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[BIT_LOCK]  = lock_q;
    rd_data_o[BIT_STEER] = steer_q;
    rd_data_o[BIT_STS]   = sts_i;
  end

  assign steer_o = steer_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/wdes_pulse.sv
module wdes_pulse #(
  parameter int unsigned PULSE_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic steer_i,
  output logic rst_no,
  output logic int_no
);
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

  logic             active_q, int_mode_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      int_mode_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!active_q) begin
      if (expire_i) begin
        active_q   <= 1'b1;
        int_mode_q <= steer_i;
        cnt_q      <= '0;
      end
    end else if (int_mode_q && !steer_i) begin
      // steering dropped mid-interrupt: restart as a full reset pulse
      int_mode_q <= 1'b0;
      cnt_q      <= '0;
    end else if (cnt_q == LAST) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_no = ~(active_q & ~int_mode_q);
  assign int_no = ~(active_q &  int_mode_q);
endmodule

// File: rtl/wd_event_steer.sv
module wd_event_steer
  import wdes_pkg::*;
#(
  parameter int unsigned PULSE_LEN   = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             sys_clk_i,
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             prot_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             expire_i,
  input  logic             dis_req_i,
  output logic             wd_disable_o,
  output logic             wd_rst_no,
  output logic             wd_int_no
);
  logic steer, lock, steer_osc, int_sts;

  wdes_regs u_regs (
    .clk_i     (sys_clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .prot_en_i (prot_en_i),
    .wr_data_i (wr_data_i),
    .sts_i     (int_sts),
    .steer_o   (steer),
    .lock_o    (lock),
    .rd_data_o (rd_data_o)
  );

  wdes_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_steer_sync (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .d_i    (steer),
    .q_o    (steer_osc)
  );

  wdes_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (osc_clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire_i),
    .steer_i  (steer_osc),
    .rst_no   (wd_rst_no),
    .int_no   (wd_int_no)
  );

  wdes_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sts_sync (
    .clk_i  (sys_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wd_int_no),
    .q_o    (int_sts)
  );

  assign wd_disable_o = dis_req_i & lock;
endmodule

// File: rtl/wd_event_steer_chk.sv
module wd_event_steer_chk (
  input logic        sys_clk_i,
  input logic        osc_clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        prot_en_i,
  input logic [15:0] rd_data_o,
  input logic        expire_i,
  input logic        dis_req_i,
  input logic        wd_disable_o,
  input logic        wd_rst_no,
  input logic        wd_int_no
);
  // R2
  reserved_zero_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    rd_data_o[15:3] == 13'd0);

  // R3
  protected_write_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !(wr_en_i && prot_en_i) |=> $stable(rd_data_o[1:0]));

  // R10
  lock_sticky_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |=> !rd_data_o[0]);

  // R11
  disable_blocked_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |-> !wd_disable_o);

  // R4
  outputs_exclusive_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    wd_rst_no || wd_int_no);

  // R8
  int_to_rst_handover_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    ($rose(wd_int_no) && !wd_rst_no) |-> $fell(wd_rst_no));
endmodule

bind wd_event_steer wd_event_steer_chk u_chk (
  .sys_clk_i    (sys_clk_i),
  .osc_clk_i    (osc_clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .prot_en_i    (prot_en_i),
  .rd_data_o    (rd_data_o),
  .expire_i     (expire_i),
  .dis_req_i    (dis_req_i),
  .wd_disable_o (wd_disable_o),
  .wd_rst_no    (wd_rst_no),
  .wd_int_no    (wd_int_no)
);

// File: tb/sim_wd_event_steer.sv
`timescale 1ns/1ps
module sim_wd_event_steer;
  localparam int PLEN = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, prot_en = 1'b0, expire = 1'b0, dis_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        wd_dis, rst_n_o, int_n_o;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  wd_event_steer u0 (
    .sys_clk_i(clk), .osc_clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .prot_en_i(prot_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .expire_i(expire), .dis_req_i(dis_req),
    .wd_disable_o(wd_dis), .wd_rst_no(rst_n_o), .wd_int_no(int_n_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic prot);
    wr_data = d; prot_en = prot; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; prot_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // counts low cycles of the selected line starting at the current negedge
  task automatic measure(input bit use_int, input int retrig_at, output int n);
    n = 0;
    while ((use_int ? int_n_o : rst_n_o) == 1'b0) begin
      n++;
      expire = (n == retrig_at);
      @(negedge clk);
      if (n > 4 * PLEN) break;
    end
    expire = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 16'h0005);
    chk("R1 rst_no", rst_n_o, 1);
    chk("R1 int_no", int_n_o, 1);
    dis_req = 1'b1; #0.1;
    chk("R1 disable follows request", wd_dis, 1);
    dis_req = 1'b0;
  endtask

  task automatic t_prot_reserved();
    wr(16'hFFFE, 1'b0);
    chk("R3 unprotected write ignored", rd_data, 16'h0005);
    wr(16'hFFFA, 1'b1);
    chk("R2 reserved read zero, R4 steer set", rd_data, 16'h0007);
    wr(16'h0004, 1'b1);
    chk("R4 steer cleared", rd_data, 16'h0005);
  endtask

  task automatic t_reset_pulse();
    int n;
    repeat (4) @(negedge clk);
    expire = 1'b1; @(negedge clk); expire = 1'b0;
    chk("R4 rst_no low", rst_n_o, 0);
    chk("R4 int_no high", int_n_o, 1);
    measure(1'b0, 100, n);
    chk("R6/R7 reset pulse length with retrigger", n, PLEN);
    chk("R4 int_no stayed high", int_n_o, 1);
  endtask

  task automatic t_int_pulse();
    int n;
    wr(16'h0002, 1'b1);
    repeat (4) @(negedge clk);
    expire = 1'b1; @(negedge clk); expire = 1'b0;
    chk("R5 int_no low", int_n_o, 0);
    chk("R5 rst_no high", rst_n_o, 1);
    chk("R9 status one edge later", rd_data[2], 1);
    @(negedge clk);
    chk("R9 status still 1 after 1 edge", rd_data[2], 1);
    @(negedge clk);
    chk("R9 status 0 after 2 edges", rd_data[2], 0);
    measure(1'b1, 0, n);
    chk("R6 interrupt pulse length", n + 2, PLEN);
    @(negedge clk);
    chk("R9 status still 0 one edge after release", rd_data[2], 0);
    @(negedge clk);
    chk("R9 status 1 after release", rd_data[2], 1);
  endtask

  task automatic t_handover();
    int n;
    repeat (4) @(negedge clk);
    expire = 1'b1; @(negedge clk); expire = 1'b0;
    repeat (50) @(negedge clk);
    wr(16'h0000, 1'b1);           // write edge s
    @(negedge clk);               // after s+1
    @(negedge clk);               // after s+2
    chk("R8 int_no still low before sync", int_n_o, 0);
    chk("R8 rst_no still high before sync", rst_n_o, 1);
    expire = 1'b1;                // lands on edge s+3
    @(negedge clk);
    expire = 1'b0;
    chk("R8 int released", int_n_o, 1);
    chk("R8 reset asserted", rst_n_o, 0);
    measure(1'b0, 0, n);
    chk("R8 fresh reset pulse length", n, PLEN);
  endtask

  task automatic t_lock();
    dis_req = 1'b1;
    wr(16'h0000, 1'b1);
    chk("R10 write 0 keeps lock", rd_data[0], 1);
    chk("R11 disable honoured", wd_dis, 1);
    wr(16'h0001, 1'b0);
    chk("R10 unprotected clear ignored", rd_data[0], 1);
    wr(16'h0001, 1'b1);
    chk("R10 lock cleared", rd_data[0], 0);
    chk("R11 disable blocked", wd_dis, 0);
    wr(16'h0000, 1'b1);
    chk("R10 lock sticky", rd_data[0], 0);
    do_reset();
    chk("R10 lock restored by reset", rd_data[0], 1);
    chk("R11 disable honoured after reset", wd_dis, 1);
    dis_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_prot_reserved();
    t_reset_pulse();
    t_int_pulse();
    t_handover();
    t_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule